// File: doc/BRIEF.md
# Configurable Input Capture Port

This block is the input stage between a row of external pins and the input bus of an on-chip logic array. Each pin runs in one of three modes before it reaches that bus. In pass mode the pin goes straight through. In latch mode it is held by a transparent latch. In register mode it is captured on a rising strobe edge.

The pins are split into groups of four. Each group has one strobe, and a per-group select bit picks where that strobe comes from: a control term supplied by the logic array, or the host address strobe. With the address strobe selected and latch mode set, the block holds address bits above the host's normal address range, and the logic array can decode them.

Every storage element is a flip-flop clocked by the system clock, and both strobes are sampled on that clock. The host writes the per-bit modes and the group source bits through a small configuration write port. Through a gated read buffer, the host reads back exactly the value the block currently drives onto the logic input bus.

Top module: `capture_port`

## Requirements
- R1: A bit whose 2-bit mode field is 00 (pass) or 11 (reserved, treated as pass) drives its pin value onto the logic input bus in the same cycle, with no clock involved.
- R2: A bit in mode 01 (latch) drives its pin value combinationally while the strobe of its group is high.
- R3: While its group strobe is low, a latch-mode bit drives the pin value sampled at the last clock edge at which that strobe was high, whatever the pin does afterwards.
- R4: A bit in mode 10 (register) takes its pin value at a clock edge where its group strobe is high and was low at the previous edge. The new value appears on the bus right after that edge. The bit holds at every other edge, including edges while the strobe stays high.
- R5: The source-select bit of group g chooses control term g when it is 0 and the address strobe when it is 1. The strobe that is not selected has no effect on that group.
- R6: Bits 4g to 4g+3 share the strobe of group g. Activity on one group's strobe leaves the other group's bits unchanged.
- R7: A configuration write at address g (g < 2) loads the mode fields of group g: data bits [2k+1:2k] set bit 4g+k. A write at address 2 loads the source-select bits: data bit g sets group g. Writes take effect at the next clock edge.
- R8: With the host read strobe high, the read data equals the logic input bus value whatever the modes are. With the read strobe low, the read data is zero.
- R9: Synchronous reset clears all held bits to zero, sets every bit to pass mode and selects the control terms as sources. A bit switched to register mode after reset therefore reads zero until its first capture.
- R10: With both groups sourced from the address strobe and in latch mode, the full pin byte present while the address strobe is high stays on the bus after the strobe falls, while the pins move on to other values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | WIDTH | External pin values |
| term_i | input | NGROUP | Control terms from the logic array, one per group |
| addr_strobe_i | input | 1 | Host address strobe |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | AW | Configuration address: group mode words, then the source-select word |
| cfg_wdata_i | input | 2*GROUP | Configuration write data |
| host_rd_i | input | 1 | Host read strobe for the readback buffer |
| host_rdata_o | output | WIDTH | Readback data, zero while not reading |
| pld_bus_o | output | WIDTH | Values presented to the logic input bus |

## Verification
The bench holds a register-mode strobe high across several edges and changes the pins meanwhile. A design that captured on level instead of on the rising edge would follow the pins there. It drops a latch strobe and changes the pins in the same cycle, which catches a latch that stays transparent one cycle too long or keeps the wrong sample. It toggles the unselected strobe and pulses only one group's strobe, so a swapped source mux or a shared strobe would disturb bits it should not touch. A mixed nibble with all four mode codes exposes any bit-to-field misalignment in the mode register.

// File: rtl/capture_port.sv
module capture_port #(
  parameter int WIDTH = 8,
  parameter int GROUP = 4,
  localparam int NGROUP = WIDTH / GROUP,
  localparam int MW = 2 * GROUP,
  localparam int AW = $clog2(NGROUP + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIDTH-1:0]  pin_i,
  input  logic [NGROUP-1:0] term_i,
  input  logic              addr_strobe_i,
  input  logic              cfg_we_i,
  input  logic [AW-1:0]     cfg_addr_i,
  input  logic [MW-1:0]     cfg_wdata_i,
  input  logic              host_rd_i,
  output logic [WIDTH-1:0]  host_rdata_o,
  output logic [WIDTH-1:0]  pld_bus_o
);

  logic [2*WIDTH-1:0] mode_q;
  logic [NGROUP-1:0]  src_q, strobe, strobe_q, rise;
  logic [WIDTH-1:0]   store_q, load, lat_m, reg_m;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      src_q  <= '0;
    end else if (cfg_we_i) begin
      for (int g = 0; g < NGROUP; g++)
        if (cfg_addr_i == AW'(g)) mode_q[g*MW +: MW] <= cfg_wdata_i;
      if (cfg_addr_i == AW'(NGROUP)) src_q <= cfg_wdata_i[NGROUP-1:0];
    end
  end

  for (genvar g = 0; g < NGROUP; g++) begin : g_grp
    assign strobe[g] = src_q[g] ? addr_strobe_i : term_i[g];
    assign rise[g]   = strobe[g] & ~strobe_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= '0;
      store_q  <= '0;
    end else begin
      strobe_q <= strobe;
      store_q  <= (store_q & ~load) | (pin_i & load);
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    localparam int G = i / GROUP;
    assign lat_m[i] = (mode_q[2*i +: 2] == 2'b01);
    assign reg_m[i] = (mode_q[2*i +: 2] == 2'b10);
    assign load[i]  = (lat_m[i] & strobe[G]) | (reg_m[i] & rise[G]);
    assign pld_bus_o[i] = lat_m[i] ? (strobe[G] ? pin_i[i] : store_q[i])
                        : reg_m[i] ? store_q[i]
                        : pin_i[i];

    // R1
    pass_follows_pin_chk: assert property (@(posedge clk) disable iff (rst)
      (!lat_m[i] && !reg_m[i]) |-> pld_bus_o[i] == pin_i[i]);
    // R2
    latch_open_chk: assert property (@(posedge clk) disable iff (rst)
      (lat_m[i] && strobe[G]) |-> pld_bus_o[i] == pin_i[i]);
    // R3
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (lat_m[i] && !strobe[G]) |=> (!lat_m[i] || strobe[G] || $stable(pld_bus_o[i])));
    // R4
    reg_capture_chk: assert property (@(posedge clk) disable iff (rst)
      (reg_m[i] && strobe[G] && !$past(strobe[G]) && !$past(rst))
        |=> (!reg_m[i] || pld_bus_o[i] == $past(pin_i[i])));
    // R4
    reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (reg_m[i] && !(strobe[G] && !$past(strobe[G])) && !$past(rst))
        |=> (!reg_m[i] || $stable(pld_bus_o[i])));
  end

  assign host_rdata_o = host_rd_i ? pld_bus_o : '0;

  // R8
  readback_chk: assert property (@(posedge clk) disable iff (rst)
    host_rdata_o == (host_rd_i ? pld_bus_o : '0));
  // R9
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (store_q == '0 && mode_q == '0 && src_q == '0));

endmodule

// File: tb/test_capture_port.sv
module test_capture_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pin = 8'h00;
  logic [1:0] term = 2'b00;
  logic       as_s = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic       rd = 1'b0;
  logic [7:0] rdata, bus;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  capture_port i_capture_port (
    .clk(clk), .rst(rst), .pin_i(pin), .term_i(term), .addr_strobe_i(as_s),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata), .host_rd_i(rd),
    .host_rdata_o(rdata), .pld_bus_o(bus));

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic expect_bus(string req, logic [7:0] exp);
    #1;
    check(req, bus, exp);
    rd = 1'b1;
    #1;
    check({req, " R8 read"}, rdata, exp);
    rd = 1'b0;
    #1;
    check("R8 idle", rdata, 8'h00);
  endtask

  task automatic wcfg(logic [1:0] a, logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    step();
    we = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic t_reset_pass();
    do_reset();
    pin = 8'hC5;
    expect_bus("R9 R1 pass after reset", 8'hC5);
    pin = 8'h3A;
    expect_bus("R1 pass follows pin", 8'h3A);
    wcfg(2'd0, 8'hFF);
    pin = 8'h96;
    expect_bus("R1 reserved code acts as pass", 8'h96);
  endtask

  task automatic t_register();
    wcfg(2'd0, 8'hAA);
    wcfg(2'd2, 8'h00);
    term = 2'b00; pin = 8'h5A;
    step();
    expect_bus("R9 R4 cleared before capture", 8'h50);
    term[0] = 1'b1;
    step();
    expect_bus("R4 capture on rising strobe", 8'h5A);
    pin = 8'hC3;
    step();
    expect_bus("R4 no capture while strobe stays high", 8'hCA);
    term[0] = 1'b0; pin = 8'h01;
    step();
    expect_bus("R4 hold with strobe low", 8'h0A);
    term[0] = 1'b1;
    step();
    expect_bus("R4 second capture", 8'h01);
    term[0] = 1'b0;
    step();
  endtask

  task automatic t_latch();
    wcfg(2'd0, 8'h00);
    wcfg(2'd1, 8'h55);
    pin = 8'h7E;
    step();
    expect_bus("R3 latch closed holds reset value", 8'h0E);
    term[1] = 1'b1;
    expect_bus("R2 latch transparent", 8'h7E);
    pin = 8'h3B;
    expect_bus("R2 latch follows pin", 8'h3B);
    step();
    term[1] = 1'b0; pin = 8'hF0;
    expect_bus("R3 latch holds after strobe falls", 8'h30);
    step();
    expect_bus("R3 latch still holds", 8'h30);
  endtask

  task automatic t_addr_strobe();
    term = 2'b00;
    wcfg(2'd2, 8'h03);
    wcfg(2'd0, 8'h55);
    term = 2'b11; pin = 8'hEE;
    step();
    expect_bus("R5 control terms ignored when strobe source chosen", 8'h31);
    as_s = 1'b1; pin = 8'hA6;
    expect_bus("R10 address passes while strobe high", 8'hA6);
    step();
    as_s = 1'b0; pin = 8'h00;
    expect_bus("R10 address held after strobe falls", 8'hA6);
    step();
    expect_bus("R10 address still held", 8'hA6);
    term = 2'b00;
    step();
  endtask

  task automatic t_groups();
    wcfg(2'd0, 8'hAA);
    wcfg(2'd1, 8'hAA);
    wcfg(2'd2, 8'h02);
    pin = 8'h12;
    step();
    expect_bus("R6 both groups hold", 8'hA6);
    term[0] = 1'b1;
    step();
    expect_bus("R6 low strobe updates low group only", 8'hA2);
    term[0] = 1'b0; as_s = 1'b1; pin = 8'h34;
    step();
    expect_bus("R5 R6 address strobe clocks high group only", 8'h32);
    as_s = 1'b0;
    step();
  endtask

  task automatic t_mixed();
    wcfg(2'd2, 8'h00);
    wcfg(2'd1, 8'h00);
    wcfg(2'd0, 8'hE4);
    pin = 8'h0F;
    step();
    expect_bus("R7 mixed fields strobe low", 8'h0B);
    term[0] = 1'b1;
    expect_bus("R7 mixed fields strobe raised", 8'h0B);
    step();
    expect_bus("R7 mixed fields after edge", 8'h0F);
    pin = 8'h00;
    expect_bus("R7 mixed fields pins drop", 8'h04);
    step();
    expect_bus("R7 mixed fields strobe held high", 8'h04);
    term[0] = 1'b0; pin = 8'h0F;
    expect_bus("R7 mixed fields strobe low again", 8'h0D);
    step();
  endtask

  task automatic t_reset_again();
    pin = 8'hFF;
    do_reset();
    expect_bus("R9 reset returns to pass", 8'hFF);
    wcfg(2'd0, 8'hAA);
    expect_bus("R9 held bits cleared by reset", 8'hF0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    t_reset_pass();
    t_register();
    t_latch();
    t_addr_strobe();
    t_groups();
    t_mixed();
    t_reset_again();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule